// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash bus and turns single requests into complete bus transactions. A request is a read, a byte program, a sector erase or a whole-device erase. The host hands it over on a valid/ready handshake. For a read the block runs one timed read cycle. For the other three it writes the device's unlock and command cycles in order, then keeps reading the target location until data bit 7 shows that the device's internal operation has finished.

All bus timing is counted in system clock cycles: setup before the write strobe, strobe width, hold after it, and read access time. Each operation class has its own cycle budget. If polling still misses when the budget has run out, the block drives a reset pulse to the device, waits out the recovery time and then reports an error. Every request ends with a one-cycle response that carries the data and an error flag.

Top module: `nor_flash_sequencer`

## Requirements
- R1: After reset the chip select, output enable, write strobe and device reset outputs are all high (inactive), `req_ready` is high and `rsp_valid` is low. `req_ready` is high only while the block is idle. Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide, and `req_ready` is high again in the cycle after it.
- R2: A program request (`req_op` = 1) writes four cycles as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (target, write data). Polling starts after the fourth.
- R3: A sector erase request (`req_op` = 2) writes six cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (target, 30h).
- R4: A whole-device erase request (`req_op` = 3) writes the same first five cycles as R3 and ends with (5555h, 10h).
- R5: In every write cycle, chip select is low and address and data are driven for exactly `T_SETUP` cycles before the write strobe falls. The strobe stays low for exactly `T_PULSE` cycles. Chip select, address and data are held for exactly `T_HOLD` cycles after the strobe rises. Output enable stays high throughout, and address and data do not change while the strobe is low.
- R6: A read request (`req_op` = 0) holds output enable low for exactly `T_RD` cycles with the write strobe high and the data bus released. It returns the value present in the last of those cycles on `rsp_data`, with `rsp_err` low.
- R7: Program polling finishes when the polled bit 7 equals bit 7 of the written data. The response then has `rsp_err` low and carries the full byte of that final poll.
- R8: Erase polling, for either erase kind, finishes when the polled bit 7 is 1.
- R9: When a poll misses after the budget for the operation (`TO_PROG`, `TO_SECT` or `TO_CHIP` cycles, counted from acceptance) has run out, the device reset output goes low for exactly `RST_LOW` cycles. The response follows exactly `RST_WAIT` cycles after it rises, with `rsp_err` high and the last polled byte.
- R10: A request presented while the block is busy is ignored. It causes no bus cycle and no response.
- R11: While the device reset output is low, chip select, output enable and write strobe are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 whole-device erase |
| req_addr | input | AW | Target byte address |
| req_wdata | input | DW | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Operation timed out, device was reset |
| rsp_data | output | DW | Read data or final polled value |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_doe | output | 1 | Data bus drive enable |
| fl_din | input | DW | Flash read data |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
The bench connects the block to a behavioural flash model. The model accepts only the exact unlock sequences, returns the complement of bit 7 while a program is in progress and 0 while an erase is in progress, and can be made to hang. Programming 32 addresses with a byte pattern that switches bit 7 in both directions tells a correct bit 7 comparison apart from a fixed one, because a wrong comparison ends early and returns a polled byte instead of the programmed one. Read-back after a sector erase separates the erased sector from its untouched neighbour, and read-back after a whole-device erase shows that the command byte decides the erase scope. A hanging model exercises the timeout and reset path, and a request held during a busy program shows that it is ignored.

// File: rtl/nfs_pkg.sv
`timescale 1ns/1ps
package nfs_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_READ, S_POLL, S_RST, S_RSP
  } seq_st_e;

  typedef enum logic [2:0] {
    C_IDLE, C_SET, C_PUL, C_HLD, C_ACC, C_REC
  } cyc_st_e;

  typedef enum logic [1:0] {
    R_IDLE, R_LOW, R_WAIT
  } rg_st_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // number of write cycles in the command script of an operation
  function automatic int seq_len(input op_e op);
    case (op)
      OP_PROG: return 4;
      OP_SECT, OP_CHIP: return 6;
      default: return 0;
    endcase
  endfunction

  // 1 when the script step addresses the request target instead of a command address
  function automatic logic seq_to_target(input op_e op, input logic [2:0] idx);
    return (op == OP_PROG && idx == 3'd3) || (op == OP_SECT && idx == 3'd5);
  endfunction

  function automatic logic [15:0] seq_cmd_addr(input logic [2:0] idx);
    return (idx == 3'd1 || idx == 3'd4) ? UNLOCK_B : UNLOCK_A;
  endfunction

  function automatic logic [7:0] seq_data(input op_e op, input logic [2:0] idx,
                                          input logic [7:0] wd);
    case (idx)
      3'd0, 3'd3: return (op == OP_PROG && idx == 3'd3) ? wd : 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return (op == OP_PROG) ? 8'hA0 : 8'h80;
      default:    return (op == OP_SECT) ? 8'h30 : 8'h10;
    endcase
  endfunction

  // bit 7 value that marks a finished operation
  function automatic logic poll_bit(input op_e op, input logic wd7);
    return (op == OP_PROG) ? wd7 : 1'b1;
  endfunction

endpackage

// File: rtl/nfs_buscyc.sv
`timescale 1ns/1ps
module nfs_buscyc
  import nfs_pkg::*;
#(
  parameter int AW      = 22,
  parameter int DW      = 8,
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 9,
  parameter int T_HOLD  = 4,
  parameter int T_RD    = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  output logic          fl_doe,
  input  logic [DW-1:0] fl_din,
  output logic          fl_cs_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int TMAX = imax(imax(T_SETUP, T_PULSE), imax(T_HOLD, T_RD));
  localparam int CW   = $clog2(TMAX + 1);

  cyc_st_e       cs;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          phase_end;

  assign phase_end = (cnt == '0);
  assign done      = phase_end && (cs == C_HLD || cs == C_REC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs    <= C_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else begin
      unique case (cs)
        C_IDLE: if (start) begin
          a_q <= addr;
          d_q <= wdata;
          if (is_wr) begin cs <= C_SET; cnt <= CW'(T_SETUP - 1); end
          else       begin cs <= C_ACC; cnt <= CW'(T_RD - 1);    end
        end
        C_SET: if (phase_end) begin cs <= C_PUL; cnt <= CW'(T_PULSE - 1); end
               else cnt <= cnt - 1'b1;
        C_PUL: if (phase_end) begin cs <= C_HLD; cnt <= CW'(T_HOLD - 1); end
               else cnt <= cnt - 1'b1;
        C_HLD: if (phase_end) cs <= C_IDLE;
               else cnt <= cnt - 1'b1;
        C_ACC: if (phase_end) begin
                 rdata <= fl_din;
                 cs    <= C_REC;
                 cnt   <= CW'(T_HOLD - 1);
               end else cnt <= cnt - 1'b1;
        C_REC: if (phase_end) cs <= C_IDLE;
               else cnt <= cnt - 1'b1;
        default: cs <= C_IDLE;
      endcase
    end
  end

  assign fl_addr = a_q;
  assign fl_dout = d_q;
  assign fl_doe  = (cs == C_SET) || (cs == C_PUL) || (cs == C_HLD);
  assign fl_we_n = (cs != C_PUL);
  assign fl_oe_n = (cs != C_ACC);
  assign fl_cs_n = !(fl_doe || cs == C_ACC);

  // R5: strobe only inside a selected, driven write cycle with output enable off
  p_we_inside_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_cs_n && fl_oe_n && fl_doe));
  // R5: address and data frozen while the strobe is low
  p_wr_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));
  // R6: read cycles never overlap a write strobe or a driven bus
  p_oe_excl_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_doe));
endmodule

// File: rtl/nfs_deadline.sv
`timescale 1ns/1ps
module nfs_deadline #(
  parameter int TOW = 34
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           en,
  input  logic [TOW-1:0] val,
  output logic           expired
);
  logic [TOW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= val;
    else if (en && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9: an exhausted budget stays exhausted until the next request
  p_budget_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/nfs_rstgen.sv
`timescale 1ns/1ps
module nfs_rstgen
  import nfs_pkg::*;
#(
  parameter int RST_LOW  = 100,
  parameter int RST_WAIT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pin_rst_n,
  output logic done
);
  localparam int RW = $clog2(imax(RST_LOW, RST_WAIT) + 1);

  rg_st_e        st;
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= R_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        R_IDLE: if (start) begin st <= R_LOW; cnt <= RW'(RST_LOW - 1); end
        R_LOW:  if (cnt == '0) begin st <= R_WAIT; cnt <= RW'(RST_WAIT - 1); end
                else cnt <= cnt - 1'b1;
        R_WAIT: if (cnt == '0) st <= R_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= R_IDLE;
      endcase
    end
  end

  assign pin_rst_n = (st != R_LOW);
  assign done      = (st == R_WAIT) && (cnt == '0);
endmodule

// File: rtl/nor_flash_sequencer.sv
`timescale 1ns/1ps
module nor_flash_sequencer
  import nfs_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 8,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 9,
  parameter int T_HOLD   = 4,
  parameter int T_RD     = 18,
  parameter int RST_LOW  = 100,
  parameter int RST_WAIT = 4000,
  parameter longint unsigned TO_PROG = 64'd60000,
  parameter longint unsigned TO_SECT = 64'd400000000,
  parameter longint unsigned TO_CHIP = 64'd12800000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  output logic          fl_doe,
  input  logic [DW-1:0] fl_din,
  output logic          fl_cs_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_rst_n
);
  localparam longint unsigned TO_MAX =
    (TO_CHIP > TO_SECT) ? ((TO_CHIP > TO_PROG) ? TO_CHIP : TO_PROG)
                        : ((TO_SECT > TO_PROG) ? TO_SECT : TO_PROG);
  localparam int TOW = $clog2(TO_MAX + 1);

  seq_st_e       st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          err_q;
  logic [2:0]    step_q;
  logic          launched;

  // named internal events
  logic          accept, cyc_start, cyc_done, cyc_wr, last_step;
  logic          poll_hit, budget_out, give_up, rg_done;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_wdata, cyc_rdata;
  logic [TOW-1:0] budget;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign cyc_wr    = (st == S_WR);
  assign cyc_start = (st == S_WR || st == S_READ || st == S_POLL) && !launched;
  assign cyc_addr  = (!cyc_wr || seq_to_target(op_q, step_q)) ? addr_q
                                                             : AW'(seq_cmd_addr(step_q));
  assign cyc_wdata = cyc_wr ? DW'(seq_data(op_q, step_q, wd_q[7:0])) : '0;
  assign last_step = (int'(step_q) == seq_len(op_q) - 1);
  assign poll_hit  = (cyc_rdata[7] == poll_bit(op_q, wd_q[7]));
  assign give_up   = (st == S_POLL) && cyc_done && !poll_hit && budget_out;

  always_comb begin
    unique case (op_e'(req_op))
      OP_SECT: budget = TOW'(TO_SECT);
      OP_CHIP: budget = TOW'(TO_CHIP);
      default: budget = TOW'(TO_PROG);
    endcase
  end

  nfs_buscyc #(.AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
               .T_HOLD(T_HOLD), .T_RD(T_RD)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_wr(cyc_wr),
    .addr(cyc_addr), .wdata(cyc_wdata), .done(cyc_done), .rdata(cyc_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
    .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  nfs_deadline #(.TOW(TOW)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(accept), .en(st != S_IDLE),
    .val(budget), .expired(budget_out));

  nfs_rstgen #(.RST_LOW(RST_LOW), .RST_WAIT(RST_WAIT)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(give_up), .pin_rst_n(fl_rst_n), .done(rg_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_READ;
      addr_q   <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      err_q    <= 1'b0;
      step_q   <= '0;
      launched <= 1'b0;
    end else begin
      if (cyc_start)     launched <= 1'b1;
      else if (cyc_done) launched <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          step_q <= '0;
          err_q  <= 1'b0;
          st     <= (op_e'(req_op) == OP_READ) ? S_READ : S_WR;
        end
        S_WR: if (cyc_done) begin
          if (last_step) st <= S_POLL;
          else           step_q <= step_q + 1'b1;
        end
        S_READ: if (cyc_done) begin
          rd_q <= cyc_rdata;
          st   <= S_RSP;
        end
        S_POLL: if (cyc_done) begin
          rd_q <= cyc_rdata;
          if (poll_hit)     st <= S_RSP;
          else if (give_up) begin err_q <= 1'b1; st <= S_RST; end
        end
        S_RST: if (rg_done) st <= S_RSP;
        S_RSP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st == S_RSP);
  assign rsp_err   = err_q;
  assign rsp_data  = rd_q;

  // R1: response is a single-cycle pulse followed by readiness
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R7 / R8: a clean completion carries the finishing bit 7
  p_ok_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && op_q != OP_READ) |-> (rsp_data[7] == poll_bit(op_q, wd_q[7])));
  // R11: bus strobes idle while the device is held in reset
  p_quiet_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_cs_n && fl_oe_n && fl_we_n));
  // R10: no request is taken while busy
  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !req_ready);
endmodule

// File: tb/nor_flash_sequencer_tb.sv
`timescale 1ns/1ps
module nor_flash_sequencer_tb_top;
  localparam int T_SETUP = 2, T_PULSE = 3, T_HOLD = 2, T_RD = 3;
  localparam int RST_LOW = 5, RST_WAIT = 7;
  localparam int TO_PROG = 200, TO_SECT = 400, TO_CHIP = 600;
  localparam int PBUSY = 30, EBUSY = 80, CBUSY = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [7:0]  rsp_data;
  logic [15:0] fl_addr;
  logic [7:0]  fl_dout, fl_din;
  logic        fl_doe, fl_cs_n, fl_oe_n, fl_we_n, fl_rst_n;

  nor_flash_sequencer #(
    .AW(16), .DW(8), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_RD(T_RD),
    .RST_LOW(RST_LOW), .RST_WAIT(RST_WAIT),
    .TO_PROG(64'(TO_PROG)), .TO_SECT(64'(TO_SECT)), .TO_CHIP(64'(TO_CHIP))
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
    .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n));

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [0:255];
  logic       stuck = 1'b0;
  logic       m_busy = 1'b0;
  logic [1:0] m_kind = 2'd0;   // 0 program, 1 sector, 2 whole device
  logic [7:0] m_a = '0, m_d = '0;
  int         m_cnt = 0, m_step = 0;
  logic       m_we_prev = 1'b1;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

  assign fl_din = m_busy ? ((m_kind == 2'd0) ? {~m_d[7], 7'h2A} : 8'h2A)
                         : mem[fl_addr[7:0]];

  always @(negedge clk) begin
    if (!fl_rst_n) begin
      m_busy = 1'b0;
      m_step = 0;
    end else if (m_busy) begin
      if (!stuck) begin
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          if (m_kind == 2'd0) mem[m_a] = mem[m_a] & m_d;
          else if (m_kind == 2'd1) begin
            for (int i = 0; i < 16; i++) mem[{m_a[7:4], 4'(i)}] = 8'hFF;
          end else begin
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          end
        end else m_cnt = m_cnt - 1;
      end
    end else if (fl_we_n && !m_we_prev) begin
      case (m_step)
        0: m_step = (fl_addr == 16'h5555 && fl_dout == 8'hAA) ? 1 : 0;
        1: m_step = (fl_addr == 16'h2AAA && fl_dout == 8'h55) ? 2 : 0;
        2: m_step = (fl_addr == 16'h5555 && fl_dout == 8'hA0) ? 6 :
                    (fl_addr == 16'h5555 && fl_dout == 8'h80) ? 3 : 0;
        3: m_step = (fl_addr == 16'h5555 && fl_dout == 8'hAA) ? 4 : 0;
        4: m_step = (fl_addr == 16'h2AAA && fl_dout == 8'h55) ? 5 : 0;
        5: begin
          if (fl_dout == 8'h30) begin
            m_busy = 1'b1; m_kind = 2'd1; m_a = fl_addr[7:0]; m_cnt = EBUSY;
          end else if (fl_dout == 8'h10 && fl_addr == 16'h5555) begin
            m_busy = 1'b1; m_kind = 2'd2; m_cnt = CBUSY;
          end
          m_step = 0;
        end
        6: begin
          m_busy = 1'b1; m_kind = 2'd0; m_a = fl_addr[7:0]; m_d = fl_dout; m_cnt = PBUSY;
          m_step = 0;
        end
        default: m_step = 0;
      endcase
    end
    m_we_prev = fl_we_n;
  end

  // ---------------- bus monitor ----------------
  logic [15:0] wlog_a [0:255];
  logic [7:0]  wlog_d [0:255];
  int nwr = 0, n_rsp = 0;
  int bad_we = 0, bad_setup = 0, bad_hold = 0, bad_oe = 0, bad_quiet = 0;
  int we_run = 0, oe_run = 0, pre = 0, post = 0, rlow = 0, last_rlow = 0;
  int gap = 0, last_gap = 0;
  bit after = 0, gap_on = 0;
  logic mon_we_prev = 1'b1, mon_rst_prev = 1'b1;

  always @(negedge clk) begin
    if (fl_we_n && !mon_we_prev) begin
      wlog_a[nwr & 255] = fl_addr;
      wlog_d[nwr & 255] = fl_dout;
      nwr++;
    end
    if (!fl_we_n) we_run++;
    else if (we_run > 0) begin if (we_run != T_PULSE) bad_we++; we_run = 0; end
    if (!fl_oe_n) oe_run++;
    else if (oe_run > 0) begin if (oe_run != T_RD) bad_oe++; oe_run = 0; end
    if (fl_cs_n) begin
      if (after && post != T_HOLD) bad_hold++;
      pre = 0; post = 0; after = 0;
    end else if (!fl_we_n) begin
      if (mon_we_prev && pre != T_SETUP) bad_setup++;
      if (!fl_doe || !fl_oe_n) bad_setup++;
      after = 1;
    end else if (after) post++;
    else if (fl_doe) pre++;
    if (!fl_rst_n) begin
      rlow++;
      if (!fl_cs_n || !fl_oe_n || !fl_we_n) bad_quiet++;
    end else if (!mon_rst_prev) begin
      last_rlow = rlow; rlow = 0; gap = 1; gap_on = 1;
    end else if (gap_on) begin
      if (rsp_valid) begin last_gap = gap; gap_on = 0; end
      else gap++;
    end
    if (rsp_valid) n_rsp++;
    mon_we_prev = fl_we_n;
    mon_rst_prev = fl_rst_n;
  end

  // ---------------- checking helpers ----------------
  int total = 0, bad = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input longint act, input longint lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                        output logic err, output logic [7:0] q, output int cyc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid) begin @(negedge clk); cyc++; end
    err = rsp_err; q = rsp_data;
    @(negedge clk);
    chk("R1 rsp pulse width", rsp_valid, 0);
    chk("R1 ready after rsp", req_ready, 1);
  endtask

  task automatic chk_wr(input string tag, input int idx, input logic [15:0] ea,
                        input logic [7:0] ed);
    chk({tag, " addr"}, wlog_a[idx & 255], ea);
    chk({tag, " data"}, wlog_d[idx & 255], ed);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic err;
    logic [7:0] q;
    int cyc, base, rbase;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset cs_n", fl_cs_n, 1);
    chk("R1 reset we_n", fl_we_n, 1);
    chk("R1 reset oe_n", fl_oe_n, 1);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle dev reset high", fl_rst_n, 1);

    // R2 / R7: program sweep
    for (int a = 0; a < 32; a++) begin
      base = nwr;
      run_op(2'd1, 16'(a), pat(a), err, q, cyc);
      chk("R7 prog err", err, 0);
      chk("R7 prog final poll", q, pat(a));
      chk("R2 prog write count", nwr - base, 4);
      chk_wr("R2 w0", base, 16'h5555, 8'hAA);
      chk_wr("R2 w1", base + 1, 16'h2AAA, 8'h55);
      chk_wr("R2 w2", base + 2, 16'h5555, 8'hA0);
      chk_wr("R2 w3", base + 3, 16'(a), pat(a));
      chk_ge("R7 prog waited", cyc, PBUSY);
    end
    // R6: read back
    for (int a = 0; a < 32; a++) begin
      run_op(2'd0, 16'(a), 8'h00, err, q, cyc);
      chk("R6 read data", q, pat(a));
      chk("R6 read err", err, 0);
    end
    chk("R5 strobe width", bad_we, 0);
    chk("R5 setup", bad_setup, 0);
    chk("R5 hold", bad_hold, 0);
    chk("R6 oe width", bad_oe, 0);

    // R3 / R8: sector erase of sector 1
    base = nwr;
    run_op(2'd2, 16'h0013, 8'h00, err, q, cyc);
    chk("R8 sect err", err, 0);
    chk("R8 sect final poll", q, 8'hFF);
    chk_ge("R8 sect waited", cyc, EBUSY);
    chk("R3 sect write count", nwr - base, 6);
    chk_wr("R3 w0", base, 16'h5555, 8'hAA);
    chk_wr("R3 w1", base + 1, 16'h2AAA, 8'h55);
    chk_wr("R3 w2", base + 2, 16'h5555, 8'h80);
    chk_wr("R3 w3", base + 3, 16'h5555, 8'hAA);
    chk_wr("R3 w4", base + 4, 16'h2AAA, 8'h55);
    chk_wr("R3 w5", base + 5, 16'h0013, 8'h30);
    for (int a = 0; a < 32; a++) begin
      run_op(2'd0, 16'(a), 8'h00, err, q, cyc);
      chk("R3 after sector erase", q, (a < 16) ? pat(a) : 8'hFF);
    end

    // R4 / R8: whole-device erase
    base = nwr;
    run_op(2'd3, 16'h0000, 8'h00, err, q, cyc);
    chk("R8 chip err", err, 0);
    chk_ge("R8 chip waited", cyc, CBUSY);
    chk("R4 chip write count", nwr - base, 6);
    chk_wr("R4 w2", base + 2, 16'h5555, 8'h80);
    chk_wr("R4 w5", base + 5, 16'h5555, 8'h10);
    for (int a = 0; a < 16; a++) begin
      run_op(2'd0, 16'(a), 8'h00, err, q, cyc);
      chk("R4 after chip erase", q, 8'hFF);
    end

    // R10: request held while busy
    base = nwr; rbase = n_rsp;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0020; req_wdata = 8'h5A;
    @(negedge clk);
    req_op = 2'd0; req_addr = 16'h0003;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R10 writes while busy", nwr - base, 4);
    chk("R10 responses", n_rsp - rbase, 1);
    run_op(2'd0, 16'h0020, 8'h00, err, q, cyc);
    chk("R10 programmed value", q, 8'h5A);

    // R9 / R11: timeout on a hung program
    stuck = 1'b1;
    run_op(2'd1, 16'h0041, 8'h12, err, q, cyc);
    stuck = 1'b0;
    chk("R9 prog timeout err", err, 1);
    chk("R9 last poll bit7", q[7], 1);
    chk_ge("R9 prog budget", cyc, TO_PROG);
    chk("R9 reset low width", last_rlow, RST_LOW);
    chk("R9 reset recovery", last_gap, RST_WAIT);
    chk("R11 quiet in reset", bad_quiet, 0);
    run_op(2'd0, 16'h0041, 8'h00, err, q, cyc);
    chk("R9 device back in read", q, 8'hFF);

    // R9: timeout on a hung sector erase
    stuck = 1'b1;
    run_op(2'd2, 16'h0030, 8'h00, err, q, cyc);
    stuck = 1'b0;
    chk("R9 sect timeout err", err, 1);
    chk("R9 sect last poll bit7", q[7], 0);
    chk_ge("R9 sect budget", cyc, TO_SECT);
    chk("R11 quiet in reset 2", bad_quiet, 0);
    chk("R5 strobe width end", bad_we, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule